// File: doc/BRIEF.md
# Early/Late Vote-or-Sum Phase Loop

This block closes the digital half of a clock and data recovery loop built around a phase interpolator. Each accepted word brings two 16-lane vectors from a deserialized bang-bang phase detector, one bit per lane for "sample early" and one for "sample late". The block reduces the word to one signed phase error, either by summing (early count minus late count) or by a majority vote that keeps only the sign. That error feeds a second-order loop filter: a proportional path and an integral path, both scaled by power-of-two shifts.

The filter output is added into a divider accumulator. Each time the accumulator reaches plus or minus the programmed divide value, the accumulator gives back that value and the block emits one up or one down step. Each step moves a wrapping interpolator code by one. The divide value is the knob that sets loop gain. Halving it restores bandwidth that transition filtering or voting removed upstream.

A small sequencer steps every accepted word through three named states. ST_IDLE waits for a word. IDLE→FILTER (on a valid strobe) captures the word and its configuration. In ST_FILTER the integrator and the proportional term are evaluated, then FILTER→STEP always follows. ST_STEP applies the divider and the code change. From there STEP→FILTER is taken when a new word arrives, and STEP→IDLE otherwise.

Top module: `elpi_loop`

## Requirements
- R1: A synchronous active-high reset clears the interpolator code to 0, both step strobes to 0, and the integral and divider accumulators to 0.
- R2: With `cfg_vote`=0 the phase error is the number of set bits in `early_vec` minus the number of set bits in `late_vec`. Bit i of each vector belongs to lane i, and a positive error steers toward up steps.
- R3: With `cfg_vote`=1 the phase error is +1 when early bits outnumber late bits, -1 when late bits outnumber early bits, and 0 when the counts are equal (including both zero).
- R4: The proportional term is the phase error multiplied by 2^`cfg_kp`.
- R5: With `cfg_ki`=n>0 the integrator adds the error multiplied by 2^(n-1), saturating at ±2047, and the filter output is the proportional term plus the updated integrator. With `cfg_ki`=0 the integral path contributes nothing and the integrator holds its value.
- R6: The filter output is added into a divider accumulator that saturates at ±32767. If the result is ≥ D, one up step is issued and D is subtracted. Otherwise, if it is ≤ -D, one down step is issued and D is added. D is `cfg_div`, and a value of 0 is treated as 1. At most one step is issued per word.
- R7: An up step increments `pi_code` and a down step decrements it, both modulo 128 (127+1 wraps to 0, and 0-1 wraps to 127).
- R8: The step strobes and the new code appear two clock edges after the edge that accepts a word. Each strobe is high for exactly one cycle, and the two strobes are never high together.
- R9: A valid strobe in the cycle right after an accepted word (state ST_FILTER) is ignored. Words may be accepted at most every second cycle.
- R10: The mode, gains and divide value are sampled together with the word at acceptance. Later changes do not affect a word already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | A deserialized early/late word is present |
| early_vec | input | 16 | Per-lane early indications |
| late_vec | input | 16 | Per-lane late indications |
| cfg_vote | input | 1 | 1 = majority vote, 0 = summation |
| cfg_kp | input | 3 | Proportional shift |
| cfg_ki | input | 3 | 0 = integral off, n = integral shift n-1 |
| cfg_div | input | 12 | Divider threshold (0 acts as 1) |
| pi_code | output | 7 | Phase interpolator code |
| step_up | output | 1 | One-cycle up step pulse |
| step_dn | output | 1 | One-cycle down step pulse |

## Verification
On every cycle the assertions cover the step-strobe rules. The strobes must be mutually exclusive, they may only appear after an ST_STEP cycle, and the code may move only by one in the direction of the strobe and must otherwise hold. They also cover the sequencer: ST_FILTER is always followed by ST_STEP, which is what makes a strobe in that state get dropped. The integrator's saturation bound is asserted as well. The arithmetic can only be shown by the bench scenarios: the vote-versus-sum reduction, the shift gains, integrator saturation, divider residue and saturation, the zero-divide rule and configuration sampling. The bench shows these by comparing the strobes and the code against a reference model, word by word.

// File: rtl/elpi_pkg.sv
package elpi_pkg;

    // Sequencer states of the loop
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILTER = 2'd1,
        ST_STEP   = 2'd2
    } loop_state_t;

    // Symmetric clamp of a wide signed value to +/-lim
    function automatic logic signed [31:0] clamp_sym(input logic signed [31:0] v,
                                                     input logic signed [31:0] lim);
        logic signed [31:0] r;
        if (v > lim)
            r = lim;
        else if (v < -lim)
            r = -lim;
        else
            r = v;
        return r;
    endfunction

endpackage

// File: rtl/elpi_reduce.sv
// Reduces one word of early/late lane flags to a signed phase error.
module elpi_reduce #(
    parameter int LANES = 16,
    parameter int CNT_W = 5,
    parameter int ERR_W = 6
) (
    input  logic [LANES-1:0]        early_vec,
    input  logic [LANES-1:0]        late_vec,
    input  logic                    vote,
    output logic signed [ERR_W-1:0] err
);

    logic [CNT_W-1:0]        n_early;
    logic [CNT_W-1:0]        n_late;
    logic signed [ERR_W-1:0] diff;

    // Population counts of both vectors
    always_comb begin
        n_early = '0;
        n_late  = '0;
        for (int i = 0; i < LANES; i++) begin
            n_early = n_early + CNT_W'(early_vec[i]);
            n_late  = n_late  + CNT_W'(late_vec[i]);
        end
        diff = $signed({1'b0, n_early}) - $signed({1'b0, n_late});
    end

    // Sum keeps the magnitude, vote keeps only the sign
    always_comb begin
        if (!vote)
            err = diff;
        else if (diff == '0)
            err = '0;
        else if (diff[ERR_W-1])
            err = {ERR_W{1'b1}};
        else
            err = ERR_W'(1);
    end

endmodule

// File: rtl/elpi_filter.sv
// Proportional-integral loop filter with power-of-two gains.
module elpi_filter
    import elpi_pkg::*;
#(
    parameter int ERR_W = 6,
    parameter int KP_W  = 3,
    parameter int KI_W  = 3,
    parameter int INT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [ERR_W-1:0] err,
    input  logic [KP_W-1:0]         kp,
    input  logic [KI_W-1:0]         ki,
    output logic signed [31:0]      ctrl_q,
    output logic signed [INT_W-1:0] integ_q
);

    localparam int INT_MAX = (1 << (INT_W - 1)) - 1;

    logic signed [31:0] err_x;
    logic signed [31:0] prop;
    logic signed [31:0] inc;
    logic signed [31:0] integ_nx;
    logic signed [31:0] ctrl_nx;
    logic               int_on;

    always_comb begin
        int_on   = (ki != '0);
        err_x    = 32'(err);
        prop     = err_x <<< kp;
        inc      = int_on ? (err_x <<< (ki - KI_W'(1))) : 32'sd0;
        integ_nx = clamp_sym(32'(integ_q) + inc, INT_MAX);
        ctrl_nx  = prop + (int_on ? integ_nx : 32'sd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            ctrl_q  <= '0;
        end else if (load) begin
            integ_q <= INT_W'(integ_nx);
            ctrl_q  <= ctrl_nx;
        end
    end

endmodule

// File: rtl/elpi_stepper.sv
// Loop divider: accumulates filter output and issues single code steps.
module elpi_stepper
    import elpi_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int DIV_W  = 12,
    parameter int DACC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic signed [31:0]       ctrl,
    input  logic [DIV_W-1:0]         div,
    output logic                     step_up,
    output logic                     step_dn,
    output logic [CODE_W-1:0]        code,
    output logic signed [DACC_W-1:0] dacc_q
);

    localparam int DACC_MAX = (1 << (DACC_W - 1)) - 1;

    logic signed [31:0] thr;
    logic signed [31:0] sum;
    logic signed [31:0] left;
    logic               up_nx;
    logic               dn_nx;

    always_comb begin
        thr   = (div == '0) ? 32'sd1 : $signed(32'(div));
        sum   = clamp_sym(32'(dacc_q) + ctrl, DACC_MAX);
        up_nx = 1'b0;
        dn_nx = 1'b0;
        left  = sum;
        if (sum >= thr) begin
            up_nx = 1'b1;
            left  = sum - thr;
        end else if (sum <= -thr) begin
            dn_nx = 1'b1;
            left  = sum + thr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            code    <= '0;
            dacc_q  <= '0;
        end else begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            if (fire) begin
                step_up <= up_nx;
                step_dn <= dn_nx;
                dacc_q  <= DACC_W'(left);
                if (up_nx)
                    code <= code + CODE_W'(1);
                else if (dn_nx)
                    code <= code - CODE_W'(1);
            end
        end
    end

endmodule

// File: rtl/elpi_loop.sv
// Top: word capture, sequencer, filter and divider.
module elpi_loop
    import elpi_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int KP_W   = 3,
    parameter int KI_W   = 3,
    parameter int INT_W  = 12,
    parameter int DIV_W  = 12,
    parameter int DACC_W = 16,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [LANES-1:0]  early_vec,
    input  logic [LANES-1:0]  late_vec,
    input  logic              cfg_vote,
    input  logic [KP_W-1:0]   cfg_kp,
    input  logic [KI_W-1:0]   cfg_ki,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic [CODE_W-1:0] pi_code,
    output logic              step_up,
    output logic              step_dn
);

    localparam int CNT_W = $clog2(LANES + 1);
    localparam int ERR_W = CNT_W + 1;

    loop_state_t state_q, state_nx;

    logic                     accept;
    logic                     filt_load;
    logic                     step_fire;
    logic signed [ERR_W-1:0]  err_now;
    logic signed [ERR_W-1:0]  err_q;
    logic [KP_W-1:0]          kp_q;
    logic [KI_W-1:0]          ki_q;
    logic [DIV_W-1:0]         div_q;
    logic signed [31:0]       ctrl_q;
    logic signed [INT_W-1:0]  integ_q;
    logic signed [DACC_W-1:0] dacc_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = word_vld ? ST_FILTER : ST_IDLE;
            ST_FILTER: state_nx = ST_STEP;
            ST_STEP:   state_nx = word_vld ? ST_FILTER : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State-decoded controls
    always_comb begin
        accept    = 1'b0;
        filt_load = 1'b0;
        step_fire = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept    = word_vld;
            ST_FILTER: filt_load = 1'b1;
            ST_STEP: begin
                step_fire = 1'b1;
                accept    = word_vld;
            end
            default: ;
        endcase
    end

    elpi_reduce #(
        .LANES (LANES),
        .CNT_W (CNT_W),
        .ERR_W (ERR_W)
    ) u_reduce (
        .early_vec (early_vec),
        .late_vec  (late_vec),
        .vote      (cfg_vote),
        .err       (err_now)
    );

    // Word and configuration captured together
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            kp_q  <= '0;
            ki_q  <= '0;
            div_q <= '0;
        end else if (accept) begin
            err_q <= err_now;
            kp_q  <= cfg_kp;
            ki_q  <= cfg_ki;
            div_q <= cfg_div;
        end
    end

    elpi_filter #(
        .ERR_W (ERR_W),
        .KP_W  (KP_W),
        .KI_W  (KI_W),
        .INT_W (INT_W)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .load    (filt_load),
        .err     (err_q),
        .kp      (kp_q),
        .ki      (ki_q),
        .ctrl_q  (ctrl_q),
        .integ_q (integ_q)
    );

    elpi_stepper #(
        .CODE_W (CODE_W),
        .DIV_W  (DIV_W),
        .DACC_W (DACC_W)
    ) u_stepper (
        .clk     (clk),
        .rst     (rst),
        .fire    (step_fire),
        .ctrl    (ctrl_q),
        .div     (div_q),
        .step_up (step_up),
        .step_dn (step_dn),
        .code    (pi_code),
        .dacc_q  (dacc_q)
    );

endmodule

// File: rtl/elpi_checker.sv
module elpi_checker
    import elpi_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int INT_W  = 12
) (
    input logic                    clk,
    input logic                    rst,
    input loop_state_t             state,
    input logic                    step_up,
    input logic                    step_dn,
    input logic [CODE_W-1:0]       pi_code,
    input logic signed [INT_W-1:0] integ_q
);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn}));

    assert_strobe_after_step_R8: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |-> $past(state) == ST_STEP);

    assert_code_inc_R7: assert property (@(posedge clk) disable iff (rst)
        step_up |-> pi_code == CODE_W'($past(pi_code) + CODE_W'(1)));

    assert_code_dec_R7: assert property (@(posedge clk) disable iff (rst)
        step_dn |-> pi_code == CODE_W'($past(pi_code) - CODE_W'(1)));

    assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(step_up || step_dn) |-> $stable(pi_code));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        state == ST_FILTER |=> state == ST_STEP);

    assert_integ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        integ_q != {1'b1, {(INT_W-1){1'b0}}});

endmodule

bind elpi_loop elpi_checker #(
    .CODE_W (CODE_W),
    .INT_W  (INT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state_q),
    .step_up (step_up),
    .step_dn (step_dn),
    .pi_code (pi_code),
    .integ_q (integ_q)
);

// File: tb/elpi_loop_tb.sv
module elpi_loop_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic [15:0] early_vec = '0;
    logic [15:0] late_vec = '0;
    logic        cfg_vote = 1'b0;
    logic [2:0]  cfg_kp = '0;
    logic [2:0]  cfg_ki = '0;
    logic [11:0] cfg_div = '0;
    logic [6:0]  pi_code;
    logic        step_up;
    logic        step_dn;

    int n_chk = 0;
    int n_bad = 0;
    int m_integ = 0;
    int m_dacc = 0;
    int m_code = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    elpi_loop u_dut (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (word_vld),
        .early_vec (early_vec),
        .late_vec  (late_vec),
        .cfg_vote  (cfg_vote),
        .cfg_kp    (cfg_kp),
        .cfg_ki    (cfg_ki),
        .cfg_div   (cfg_div),
        .pi_code   (pi_code),
        .step_up   (step_up),
        .step_dn   (step_dn)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int clampi(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // One word: model update, drive, then check two edges after acceptance.
    task automatic send(input string tag, input logic [15:0] e, input logic [15:0] l,
                        input bit vote, input int kp, input int ki, input int dv,
                        input bit poke);
        int err;
        int f;
        int d;
        int eu = 0;
        int ed = 0;
        err = popc(e) - popc(l);
        if (vote) err = (err > 0) ? 1 : ((err < 0) ? -1 : 0);
        f = err * (1 << kp);
        if (ki != 0) begin
            m_integ = clampi(m_integ + err * (1 << (ki - 1)), 2047);
            f = f + m_integ;
        end
        m_dacc = clampi(m_dacc + f, 32767);
        d = (dv == 0) ? 1 : dv;
        if (m_dacc >= d) begin
            eu = 1;
            m_dacc -= d;
        end else if (m_dacc <= -d) begin
            ed = 1;
            m_dacc += d;
        end
        m_code = (m_code + eu - ed) & 127;

        word_vld  = 1'b1;
        early_vec = e;
        late_vec  = l;
        cfg_vote  = vote;
        cfg_kp    = 3'(kp);
        cfg_ki    = 3'(ki);
        cfg_div   = 12'(dv);
        @(negedge clk);
        // R8: previous strobes last one cycle only
        check("R8", "strobe width up", int'(step_up), 0);
        check("R8", "strobe width dn", int'(step_dn), 0);
        if (poke) begin
            // R9 and R10: second strobe ignored, config changes too late
            word_vld  = 1'b1;
            early_vec = ~e;
            late_vec  = ~l;
            cfg_vote  = ~vote;
            cfg_kp    = 3'(7 - kp);
            cfg_ki    = 3'(7 - ki);
            cfg_div   = 12'(d + 5);
        end else begin
            word_vld = 1'b0;
        end
        @(negedge clk);
        word_vld = 1'b0;
        @(negedge clk);
        check(tag, "step_up", int'(step_up), eu);
        check(tag, "step_dn", int'(step_dn), ed);
        check(tag, "pi_code", int'(pi_code), m_code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "pi_code", int'(pi_code), 0);
        check("R1", "step_up", int'(step_up), 0);
        check("R1", "step_dn", int'(step_dn), 0);
        rst = 1'b0;

        // R7: down from 0 wraps to 127, then back up
        send("R7", 16'h0000, 16'hFFFF, 1'b0, 0, 0, 1, 1'b0);
        send("R7", 16'hFFFF, 16'h0000, 1'b0, 0, 0, 1, 1'b0);
        // R2: summation with partial counts
        send("R2", 16'h00FF, 16'h000F, 1'b0, 0, 0, 4, 1'b0);
        send("R2", 16'h0001, 16'h0F0F, 1'b0, 0, 0, 3, 1'b0);
        // R3: majority tie, both zero, and a win
        send("R3", 16'h0F00, 16'h00F0, 1'b1, 0, 0, 1, 1'b0);
        send("R3", 16'h0000, 16'h0000, 1'b1, 0, 0, 1, 1'b0);
        send("R3", 16'h0007, 16'h0001, 1'b1, 0, 0, 1, 1'b0);
        send("R3", 16'h0001, 16'hFFF0, 1'b1, 2, 0, 3, 1'b0);
        // R4: proportional shift against a large threshold
        send("R4", 16'h0003, 16'h0000, 1'b0, 7, 0, 200, 1'b0);
        send("R4", 16'h0000, 16'h0003, 1'b0, 6, 0, 100, 1'b0);
        // R5: integrator rises into saturation, then disabled
        send("R5", 16'hFFFF, 16'h0000, 1'b0, 0, 7, 4095, 1'b0);
        send("R5", 16'hFFFF, 16'h0000, 1'b0, 0, 7, 4095, 1'b0);
        send("R5", 16'hFFFF, 16'h0000, 1'b0, 0, 7, 4095, 1'b0);
        send("R5", 16'h0000, 16'h0001, 1'b0, 0, 0, 4095, 1'b0);
        send("R5", 16'h0000, 16'hFFFF, 1'b0, 3, 5, 2000, 1'b0);
        // R6: zero divide acts as one, residue carried
        send("R6", 16'h0000, 16'h0000, 1'b0, 0, 0, 0, 1'b0);
        send("R6", 16'h0001, 16'h0000, 1'b0, 0, 0, 0, 1'b0);
        // R9 and R10: ignored second strobe with late config change
        send("R9", 16'h00F0, 16'h0001, 1'b0, 1, 2, 7, 1'b1);
        send("R10", 16'h0000, 16'h0F00, 1'b1, 4, 0, 9, 1'b1);

        // Random words mixed with the same model
        for (int k = 0; k < 600; k++) begin
            logic [15:0] e;
            logic [15:0] l;
            int dv;
            e  = 16'($urandom);
            l  = 16'($urandom) & 16'($urandom);
            dv = ($urandom % 4 == 0) ? int'($urandom % 4096) : int'($urandom % 40);
            send("R6", e, l, 1'($urandom), int'($urandom % 8), int'($urandom % 8), dv,
                 1'($urandom % 5 == 0));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule